// File: doc/BRIEF.md
# I2C Indexed Block Register Target

This block is an I2C target that gives a host access to a small control register through indexed block transfers. Its 7-bit address is fixed at 0x69. In a write, the host sends the address byte 0xD2, then a one-byte register offset, then a byte count, then that many data bytes, which go to consecutive offsets. In a read, the host first sets the offset with a short write (0xD2 and the offset byte), then issues a repeated start with 0xD3. The target answers with a count byte and then register bytes, starting at that offset, until the host declines a byte.

Only offset 0 is implemented. Its low four bits drive the enables of four clock outputs. Its upper four bits are spare storage that can be read and written. SCL and SDA are sampled on the system clock through two-flop synchronisers. The target pulls SDA low through an open-drain enable. It does not stretch the clock and does not support 10-bit addressing.

Top module: `i2c_idx_regs`

## Requirements
- R1: After reset, `out_enable` is 4'hF, `spare_bits` is 4'h0 and `sda_pull` is 0.
- R2: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged by holding SDA low during the ninth clock. Any other address byte is not acknowledged, and the target then acknowledges no byte and changes no register until the next start condition.
- R3: In a write, the byte after the address is the offset and the next byte is the count X. The following X data bytes are acknowledged and stored at offset, offset+1, and so on. For offset 0, bit k of the byte drives `out_enable[k]`, where bit 3 enables output 5 and bit 0 enables output 8, and bits 7:4 drive `spare_bits[3:0]`.
- R4: A data byte sent after the X counted bytes is not acknowledged and is not stored.
- R5: Data bytes aimed at offsets 1 to 255 are acknowledged and discarded. The offset pointer is 8 bits wide and wraps from 255 to 0, so the byte after one written at offset 255 lands in register 0.
- R6: After 0xD3, the target first sends the count byte 0x01, then the byte at the current offset, with 0x00 for any unimplemented offset, advancing the offset after each byte. Bytes are sent MSB first while the host acknowledges. A host NACK makes the target release SDA.
- R7: A start or stop condition in the middle of a byte aborts the transfer without writing that partial byte. Bytes completed before the abort stay written.
- R8: The offset set by a write persists across a stop, so a later read that begins directly with 0xD3 returns data from that offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases the line |
| out_enable | output | 4 | Clock output enables: bit 3 is output 5, bit 0 is output 8 |
| spare_bits | output | 4 | Spare control bits 7:4 of register 0 |

## Verification
The bench targets the byte-count boundary. A target that ignored the count would acknowledge and store a surplus byte, so register 0 would show the extra value. It writes across offset 255. A pointer without wrap, or one that saturates, would drop the byte meant for register 0. It reads past the implemented register, where a design that mirrored register 0 would return a non-zero byte in place of 0x00. It also sends foreign addresses followed by data, which catches a target that keeps decoding after a NACK. Finally, it cuts bytes short with a stop and with a start, which catches a design that commits half-shifted data or loses the offset set before the abort.

// File: rtl/i2c_idx_regs.sv
module i2c_idx_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] CTRL_RST = 8'h0F,
  parameter int         SYNC_N   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic [3:0] out_enable,
  output logic [3:0] spare_bits
);
  localparam logic [7:0] NUM_REGS = 8'd1;
  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] BYTE_END = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_TXACK} st_t;
  typedef enum logic [1:0] {P_ADDR, P_OFFS, P_CNT, P_DATA} ph_t;

  logic [SYNC_N-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;
  st_t  st;
  ph_t  ph;
  logic [3:0] bitcnt;
  logic [7:0] sh, ptr, remain, ctrl_q;
  logic rd_mode, host_ack;

  wire scl_s = scl_sh[SYNC_N-1];
  wire sda_s = sda_sh[SYNC_N-1];
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire addr_hit  = (sh[7:1] == DEV_ADDR);
  wire in_range  = (ptr < NUM_REGS);
  wire [7:0] rd_byte = in_range ? ctrl_q : 8'h00;

  assign out_enable = ctrl_q[3:0];
  assign spare_bits = ctrl_q[7:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_N-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC_N-2:0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= P_ADDR;
      bitcnt   <= '0;
      sh       <= '0;
      ptr      <= '0;
      remain   <= '0;
      ctrl_q   <= CTRL_RST;
      rd_mode  <= 1'b0;
      host_ack <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      st       <= S_RX;
      ph       <= P_ADDR;
      bitcnt   <= '0;
      rd_mode  <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      st       <= S_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitcnt != BYTE_END) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == BYTE_END) begin
            st       <= S_ACK;
            sda_pull <= 1'b1;
            case (ph)
              P_ADDR: begin
                if (!addr_hit) begin
                  st       <= S_IDLE;
                  sda_pull <= 1'b0;
                end else begin
                  rd_mode <= sh[0];
                  ph      <= P_OFFS;
                end
              end
              P_OFFS: begin
                ptr <= sh;
                ph  <= P_CNT;
              end
              P_CNT: begin
                remain <= sh;
                ph     <= P_DATA;
              end
              default: begin
                if (remain == 8'd0) begin
                  st       <= S_IDLE;
                  sda_pull <= 1'b0;
                end else begin
                  if (in_range) ctrl_q <= sh;
                  ptr    <= ptr + 8'd1;
                  remain <= remain - 8'd1;
                end
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rd_mode) begin
              st       <= S_TX;
              sh       <= NUM_REGS;
              sda_pull <= ~NUM_REGS[7];
            end else begin
              st       <= S_RX;
              sda_pull <= 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitcnt == LAST_BIT) begin
              st       <= S_TXACK;
              sda_pull <= 1'b0;
            end else begin
              sh       <= {sh[6:0], 1'b0};
              sda_pull <= ~sh[6];
              bitcnt   <= bitcnt + 4'd1;
            end
          end
        end
        S_TXACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (host_ack) begin
              st       <= S_TX;
              sh       <= rd_byte;
              sda_pull <= ~rd_byte[7];
              ptr      <= ptr + 8'd1;
              bitcnt   <= '0;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_idx_regs_chk.sv
module i2c_idx_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       stop_det,
  input logic [2:0] st_code,
  input logic       sda_pull,
  input logic [7:0] ctrl_q,
  input logic [3:0] out_enable
);
  localparam logic [2:0] TX_CODE = 3'd3;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_enable == 4'hF && !sda_pull));

  // R2
  pull_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  // R3
  reg_write_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(scl_fall));

  // R6
  tx_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == TX_CODE && $past(st_code) == TX_CODE && !$past(scl_fall)) |-> $stable(sda_pull));

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);
endmodule

bind i2c_idx_regs i2c_idx_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .stop_det(stop_det), .st_code(st), .sda_pull(sda_pull),
  .ctrl_q(ctrl_q), .out_enable(out_enable)
);

// File: tb/sim_i2c_idx_regs.sv
module sim_i2c_idx_regs;
  localparam int Q = 200;

  logic clk = 1'b0, rst_n = 1'b0, scl_h = 1'b1, sda_h = 1'b1;
  logic sda_pull;
  logic [3:0] out_enable, spare_bits;
  wire sda_bus = sda_h & ~sda_pull;

  i2c_idx_regs u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_bus),
    .sda_pull(sda_pull), .out_enable(out_enable), .spare_bits(spare_bits)
  );

  always #5 clk = ~clk;

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t      exp_q[$];
  logic [7:0] obs_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  initial forever begin
    item_t e;
    logic [7:0] o;
    wait (obs_q.size() > 0 && exp_q.size() > 0);
    e = exp_q.pop_front();
    o = obs_q.pop_front();
    n_chk++;
    if (o !== e.v) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", e.tag, o, e.v);
    end
  end

  task automatic bus_bit(input logic b, output logic smp);
    sda_h = b; #Q; scl_h = 1'b1; #Q; smp = sda_bus; #Q; scl_h = 1'b0; #Q;
  endtask

  task automatic i2c_start;
    sda_h = 1'b1; #Q; scl_h = 1'b1; #Q; sda_h = 1'b0; #Q; scl_h = 1'b0; #Q;
  endtask

  task automatic i2c_stop;
    sda_h = 1'b0; #Q; scl_h = 1'b1; #Q; sda_h = 1'b1; #Q;
  endtask

  task automatic wbyte(input logic [7:0] b, input logic ack_exp, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    exp_q.push_back('{v: {7'd0, ~ack_exp}, tag: tag});
    bus_bit(1'b1, s);
    obs_q.push_back({7'd0, s});
  endtask

  task automatic rbyte(input logic [7:0] e, input logic give_ack, input string tag);
    logic [7:0] d;
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, s);
      d = {d[6:0], s};
    end
    exp_q.push_back('{v: e, tag: tag});
    obs_q.push_back(d);
    bus_bit(~give_ack, s);
  endtask

  task automatic pbits(input int n, input logic [7:0] b);
    logic s;
    for (int i = 0; i < n; i++) bus_bit(b[7-i], s);
  endtask

  task automatic chk_regs(input logic [7:0] e, input string tag);
    exp_q.push_back('{v: e, tag: tag});
    obs_q.push_back({spare_bits, out_enable});
  endtask

  task automatic chk_idle(input string tag);
    exp_q.push_back('{v: 8'h00, tag: tag});
    obs_q.push_back({7'd0, sda_pull});
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1; #47; rst_n = 1'b1; #Q;
    chk_regs(8'h0F, "R1 reset regs");
    chk_idle("R1 reset pull");

    i2c_start; wbyte(8'hD2, 1, "R2 write addr"); wbyte(8'h00, 1, "R3 offset");
    wbyte(8'h01, 1, "R3 count"); wbyte(8'hA5, 1, "R3 data"); i2c_stop;
    chk_regs(8'hA5, "R3 reg0 A5");

    i2c_start; wbyte(8'hD2, 1, "R4 addr"); wbyte(8'h00, 1, "R4 offset");
    wbyte(8'h01, 1, "R4 count"); wbyte(8'h3C, 1, "R4 data");
    wbyte(8'h99, 0, "R4 surplus nack"); i2c_stop;
    chk_regs(8'h3C, "R4 surplus not stored");

    i2c_start; wbyte(8'hD2, 1, "R5 addr"); wbyte(8'h03, 1, "R5 offset");
    wbyte(8'h02, 1, "R5 count"); wbyte(8'h11, 1, "R5 oor ack");
    wbyte(8'h22, 1, "R5 oor ack2"); i2c_stop;
    chk_regs(8'h3C, "R5 oor discarded");

    i2c_start; wbyte(8'hD2, 1, "R5 addr"); wbyte(8'hFF, 1, "R5 offset FF");
    wbyte(8'h02, 1, "R5 count"); wbyte(8'h77, 1, "R5 at FF");
    wbyte(8'hC3, 1, "R5 wrapped"); i2c_stop;
    chk_regs(8'hC3, "R5 wrap to reg0");

    i2c_start; wbyte(8'hA0, 0, "R2 foreign nack"); wbyte(8'h00, 0, "R2 ignored1");
    wbyte(8'h01, 0, "R2 ignored2"); wbyte(8'h5A, 0, "R2 ignored3"); i2c_stop;
    chk_regs(8'hC3, "R2 regs kept");
    i2c_start; wbyte(8'hD0, 0, "R2 near addr nack"); i2c_stop;

    i2c_start; wbyte(8'hD2, 1, "R6 addr"); wbyte(8'h00, 1, "R6 offset");
    i2c_start; wbyte(8'hD3, 1, "R2 read addr");
    rbyte(8'h01, 1, "R6 count"); rbyte(8'hC3, 1, "R6 reg0");
    rbyte(8'h00, 0, "R6 past end"); i2c_stop;
    chk_idle("R6 released");

    i2c_start; wbyte(8'hD2, 1, "R6 addr"); wbyte(8'h07, 1, "R6 offset7");
    i2c_start; wbyte(8'hD3, 1, "R6 read addr");
    rbyte(8'h01, 1, "R6 count"); rbyte(8'h00, 0, "R6 oor read"); i2c_stop;

    i2c_start; wbyte(8'hD2, 1, "R8 addr"); wbyte(8'h00, 1, "R8 offset"); i2c_stop;
    i2c_start; wbyte(8'hD3, 1, "R8 read addr");
    rbyte(8'h01, 1, "R8 count"); rbyte(8'hC3, 0, "R8 kept offset"); i2c_stop;

    i2c_start; wbyte(8'hD2, 1, "R7 addr"); wbyte(8'h00, 1, "R7 offset");
    wbyte(8'h02, 1, "R7 count"); wbyte(8'h4B, 1, "R7 full byte");
    pbits(4, 8'hE0); i2c_stop;
    chk_regs(8'h4B, "R7 stop abort");
    chk_idle("R7 idle after stop");

    i2c_start; wbyte(8'hD2, 1, "R7 addr"); wbyte(8'h00, 1, "R7 offset");
    wbyte(8'h01, 1, "R7 count"); pbits(3, 8'h20);
    i2c_start; wbyte(8'hD3, 1, "R7 read after start");
    rbyte(8'h01, 1, "R7 count"); rbyte(8'h4B, 0, "R7 start abort"); i2c_stop;
    chk_regs(8'h4B, "R7 regs after start abort");

    #(4*Q);
    wait (obs_q.size() == 0);
    #Q;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule